// File: doc/BRIEF.md
# Load/Store Data Formatter with Hardwired Zero Register

This block sits between the register file and a 32-bit little-endian data memory port of a RISC core. For each accepted request it forms the effective address from a base register value and a sign-extended 16-bit immediate. It then places store data on the correct byte lanes with matching byte enables, or pulls the addressed byte, halfword or word out of the memory read word for register writeback. Sub-word loads come in sign-extending and zero-extending forms. A writeback aimed at register 0 is dropped, because that register always reads as zero.

Double-precision accesses move an even/odd register pair as two word beats on consecutive cycles. The first beat carries the even register at the effective address. The second beat carries the odd register at the address plus 4. Requests arrive on a valid/ready handshake: a request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` drops for the cycle of a second beat, so a requester must hold its request until it sees `req_ready` high. The store data for both beats is captured when the request is taken. The memory port has no handshake: it takes an access in any cycle where `mem_en` is high, and it returns read data in that same cycle.

A halfword access at an odd address, or a word, float or double access whose address is not a multiple of 4, is not performed. Such a request raises `misalign` for its accept cycle instead.

Top module: `ldst_formatter`

## Requirements
- R1: In the cycle a request is accepted, `mem_addr` equals `req_base` plus `req_imm` sign-extended to 32 bits, with wrap-around modulo 2^32.
- R2: Op codes 0 (byte, signed) and 2 (halfword, signed) sign-extend, and op codes 1 (byte, unsigned) and 3 (halfword, unsigned) zero-extend. Memory is little-endian: the byte comes from lane `addr[1:0]` (lane k is bits 8k+7..8k), and the halfword comes from bits 31..16 when `addr[1]` is 1 and from bits 15..0 otherwise.
- R3: Op codes 4 (word) and 5 (single float) write the full read word back to `req_rd` in the accept cycle.
- R4: Op code 8 (byte store) puts the low byte of `req_sdata` on all four lanes with `mem_be` = 1 << `addr[1:0]`. Op code 9 (halfword store) puts bits 15..0 on both halves with `mem_be` 4'b0011, or 4'b1100 when `addr[1]` is 1. Op codes 10 (word) and 11 (single float) write `req_sdata[31:0]` with `mem_be` 4'b1111. `mem_we` is high only for stores.
- R5: A load that writes register 0 never raises `wb_en`, and no other part of the access changes because of it.
- R6: Op codes 6 (double load) and 12 (double store) take two beats. In the accept cycle, register `{req_rd[4:1],0}` is accessed at the effective address using `req_sdata[31:0]`. In the next cycle `busy` is 1 and `req_ready` is 0, and register `{req_rd[4:1],1}` is accessed at the address plus 4 using the captured `req_sdata[63:32]`, with all four byte enables. After that, `busy` returns to 0.
- R7: A halfword access with `addr[0]` set, or a word, float or double access with `addr[1:0]` nonzero, raises `misalign` in its accept cycle. It leaves `mem_en`, `wb_en` and `busy` low.
- R8: Op codes 7, 13, 14 and 15 are accepted but cause no memory access, no writeback and no `misalign`.
- R9: After reset, `busy`, `mem_en`, `wb_en` and `misalign` are 0 and `req_ready` is 1.
- R10: While `req_ready` is 0, a request held on the inputs is not taken. The memory port shows only the second beat, and the held request is taken in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 4 | Access-type code |
| req_rd | input | 5 | Data register index |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed address offset |
| req_sdata | input | 64 | Store data; bits 31..0 even/single register, bits 63..32 odd register |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lane-placed |
| mem_rdata | input | 32 | Read data, same cycle |
| wb_en | output | 1 | Register writeback this cycle |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 32 | Formatted writeback data |
| busy | output | 1 | Second beat of a double access in progress |
| misalign | output | 1 | Accepted request rejected for alignment |

## Verification
Two functions can land in the same cycle. One is the second beat of a double access. The other is a new request arriving and being held back. The bench provokes this by keeping `req_valid` high with a word load already presented during the busy beat. It then judges that the port shows only the odd-register beat at address plus 4 while `req_ready` is low, and that the held load completes with its own address and data in the following cycle. The zero-register rule is also crossed with the double load: a pair aimed at registers 0/1 must drop only the first writeback.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;

  typedef struct packed {
    logic  valid;
    logic  store;
    logic  sgn;
    size_e size;
  } acc_t;

  // Access-type code map: bit 3 selects store; unlisted codes are inert.
  function automatic acc_t decode_op(input logic [3:0] op);
    acc_t d;
    d = '{valid: 1'b1, store: op[3], sgn: 1'b0, size: SZ_W};
    case (op)
      4'd0:  begin d.size = SZ_B; d.sgn = 1'b1; end
      4'd1:  d.size = SZ_B;
      4'd2:  begin d.size = SZ_H; d.sgn = 1'b1; end
      4'd3:  d.size = SZ_H;
      4'd4,
      4'd5:  d.size = SZ_W;
      4'd6:  d.size = SZ_D;
      4'd8:  d.size = SZ_B;
      4'd9:  d.size = SZ_H;
      4'd10,
      4'd11: d.size = SZ_W;
      4'd12: d.size = SZ_D;
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import ldst_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int OFF_W = 2
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  size_e            size,
  output logic [XLEN-1:0]  ea,
  output logic             mis
);

  localparam int EXT_W = XLEN - IMM_W;

  assign ea = base + {{EXT_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    case (size)
      SZ_B:    mis = 1'b0;
      SZ_H:    mis = ea[0];
      default: mis = |ea[OFF_W-1:0];
    endcase
  end

endmodule

// File: rtl/lsu_sfmt.sv
module lsu_sfmt
  import ldst_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = XLEN / 8,
  parameter int OFF_W = $clog2(LANES)
) (
  input  size_e             size,
  input  logic [OFF_W-1:0]  lane,
  input  logic [XLEN-1:0]   sdata,
  output logic [LANES-1:0]  be,
  output logic [XLEN-1:0]   wdata
);

  localparam int HALVES = LANES / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
    always_comb begin
      case (size)
        SZ_B:    be[i] = (lane == IDX);
        SZ_H:    be[i] = (lane[OFF_W-1:1] == IDX[OFF_W-1:1]);
        default: be[i] = 1'b1;
      endcase
    end
  end

  always_comb begin
    case (size)
      SZ_B:    wdata = {LANES{sdata[7:0]}};
      SZ_H:    wdata = {HALVES{sdata[15:0]}};
      default: wdata = sdata;
    endcase
  end

endmodule

// File: rtl/lsu_lfmt.sv
module lsu_lfmt
  import ldst_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = $clog2(XLEN / 8)
) (
  input  size_e            size,
  input  logic             sgn,
  input  logic [OFF_W-1:0] lane,
  input  logic [XLEN-1:0]  rdata,
  output logic [XLEN-1:0]  data
);

  logic [7:0]  byte_v;
  logic [15:0] half_v;

  assign byte_v = rdata[{lane, 3'b000} +: 8];
  assign half_v = rdata[{lane[OFF_W-1:1], 4'b0000} +: 16];

  always_comb begin
    case (size)
      SZ_B:    data = {{(XLEN-8){sgn & byte_v[7]}}, byte_v};
      SZ_H:    data = {{(XLEN-16){sgn & half_v[15]}}, half_v};
      default: data = rdata;
    endcase
  end

endmodule

// File: rtl/ldst_formatter.sv
module ldst_formatter
  import ldst_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_op,
  input  logic [RIDX_W-1:0]   req_rd,
  input  logic [XLEN-1:0]     req_base,
  input  logic [IMM_W-1:0]    req_imm,
  input  logic [2*XLEN-1:0]   req_sdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [XLEN-1:0]     mem_addr,
  output logic [XLEN/8-1:0]   mem_be,
  output logic [XLEN-1:0]     mem_wdata,
  input  logic [XLEN-1:0]     mem_rdata,
  output logic                wb_en,
  output logic [RIDX_W-1:0]   wb_idx,
  output logic [XLEN-1:0]     wb_data,
  output logic                busy,
  output logic                misalign
);

  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_t              dec;
  logic [XLEN-1:0]   ea;
  logic              mis_raw;
  logic              accept;
  logic              go;

  // second-beat state
  logic              busy_q;
  logic [XLEN-1:0]   b2_addr_q;
  logic [RIDX_W-1:0] b2_rd_q;
  logic [XLEN-1:0]   b2_data_q;
  logic              b2_st_q;

  // current beat
  logic [XLEN-1:0]   cur_addr;
  logic [RIDX_W-1:0] cur_rd;
  logic [XLEN-1:0]   cur_sdata;
  logic              cur_st;
  logic              cur_sgn;
  size_e             cur_size;
  logic [LANES-1:0]  be_raw;

  assign dec       = decode_op(req_op);
  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;
  assign busy      = busy_q;

  lsu_agen #(.XLEN(XLEN), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_agen (
    .base (req_base),
    .imm  (req_imm),
    .size (dec.size),
    .ea   (ea),
    .mis  (mis_raw)
  );

  always_comb begin
    if (busy_q) begin
      go        = 1'b1;
      cur_addr  = b2_addr_q;
      cur_rd    = b2_rd_q;
      cur_sdata = b2_data_q;
      cur_st    = b2_st_q;
      cur_sgn   = 1'b0;
      cur_size  = SZ_W;
    end else begin
      go        = accept && dec.valid && !mis_raw;
      cur_addr  = ea;
      cur_rd    = (dec.size == SZ_D) ? {req_rd[RIDX_W-1:1], 1'b0} : req_rd;
      cur_sdata = req_sdata[XLEN-1:0];
      cur_st    = dec.store;
      cur_sgn   = dec.sgn;
      cur_size  = (dec.size == SZ_D) ? SZ_W : dec.size;
    end
  end

  lsu_sfmt #(.XLEN(XLEN)) u_sfmt (
    .size  (cur_size),
    .lane  (cur_addr[OFF_W-1:0]),
    .sdata (cur_sdata),
    .be    (be_raw),
    .wdata (mem_wdata)
  );

  lsu_lfmt #(.XLEN(XLEN)) u_lfmt (
    .size  (cur_size),
    .sgn   (cur_sgn),
    .lane  (cur_addr[OFF_W-1:0]),
    .rdata (mem_rdata),
    .data  (wb_data)
  );

  assign mem_en   = go;
  assign mem_we   = go && cur_st;
  assign mem_addr = cur_addr;
  assign mem_be   = go ? be_raw : '0;
  assign wb_idx   = cur_rd;
  assign wb_en    = go && !cur_st && (cur_rd != '0);
  assign misalign = !busy_q && accept && dec.valid && mis_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      b2_addr_q <= '0;
      b2_rd_q   <= '0;
      b2_data_q <= '0;
      b2_st_q   <= 1'b0;
    end else if (!busy_q && go && dec.size == SZ_D) begin
      busy_q    <= 1'b1;
      b2_addr_q <= ea + XLEN'(LANES);
      b2_rd_q   <= {req_rd[RIDX_W-1:1], 1'b1};
      b2_data_q <= req_sdata[2*XLEN-1:XLEN];
      b2_st_q   <= dec.store;
    end else begin
      busy_q    <= 1'b0;
    end
  end

  // R7
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_en && !wb_en));

  // R7
  misalign_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> !busy);

  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != '0));

  // R6
  dbl_two_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R6
  dbl_next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_en && mem_be == {LANES{1'b1}} && mem_addr == $past(mem_addr) + XLEN'(LANES)));

  // R6
  dbl_odd_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (wb_idx[0] && $past(mem_en) && !$past(wb_idx[0])));

  // R10
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R4
  store_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !busy && req_op == 4'd8) |-> $onehot(mem_be));

endmodule

// File: tb/ldst_formatter_tb.sv
`timescale 1ns/1ps
module ldst_formatter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [4:0]  req_rd = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_imm = '0;
  logic [63:0] req_sdata = '0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        busy, misalign;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [31:0] mem [0:15];

  always #4 clk = ~clk;

  ldst_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_rd(req_rd), .req_base(req_base), .req_imm(req_imm),
    .req_sdata(req_sdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .busy(busy),
    .misalign(misalign)
  );

  assign mem_rdata = mem[mem_addr[5:2]];

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Bench-side view of the access codes.
  function automatic int op_size(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd8:         return 0;
      4'd2, 4'd3, 4'd9:         return 1;
      4'd4, 4'd5, 4'd10, 4'd11: return 2;
      4'd6, 4'd12:              return 3;
      default:                  return -1;
    endcase
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [4:0] rd, input logic [31:0] base,
                       input logic [15:0] imm, input logic [63:0] sd);
    int sz;
    bit st, sg, mis, en;
    logic [31:0] a, w, v, ebe, ewd;
    logic [4:0] erd;
    sz  = op_size(op);
    st  = op[3];
    sg  = (op == 4'd0) || (op == 4'd2);
    a   = base + {{16{imm[15]}}, imm};
    mis = (sz == 1 && a[0]) || (sz >= 2 && a[1:0] != 2'b00);
    en  = (sz >= 0) && !mis;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_rd = rd; req_base = base; req_imm = imm; req_sdata = sd;
    #1;
    chk(sz < 0 ? "R8" : "R7", "misalign", {31'b0, misalign}, {31'b0, (sz >= 0) && mis});
    chk(sz < 0 ? "R8" : "R7", "mem_en", {31'b0, mem_en}, {31'b0, en});
    if (en) begin
      chk("R1", "mem_addr", mem_addr, a);
      chk("R4", "mem_we", {31'b0, mem_we}, {31'b0, st});
      if (st) begin
        case (sz)
          0: begin ebe = 32'd1 << a[1:0]; ewd = {4{sd[7:0]}}; end
          1: begin ebe = a[1] ? 32'hC : 32'h3; ewd = {2{sd[15:0]}}; end
          default: begin ebe = 32'hF; ewd = sd[31:0]; end
        endcase
        chk(sz == 3 ? "R6" : "R4", "mem_be", {28'b0, mem_be}, ebe);
        chk(sz == 3 ? "R6" : "R4", "mem_wdata", mem_wdata, ewd);
        chk("R4", "wb_en on store", {31'b0, wb_en}, 32'd0);
      end else begin
        w = mem[a[5:2]];
        case (sz)
          0: begin v = (w >> (8 * a[1:0])) & 32'hFF; if (sg && v >= 32'd128) v = v - 32'd256; end
          1: begin v = (w >> (16 * a[1])) & 32'hFFFF; if (sg && v >= 32'd32768) v = v - 32'd65536; end
          default: v = w;
        endcase
        erd = (sz == 3) ? {rd[4:1], 1'b0} : rd;
        chk("R5", "wb_en", {31'b0, wb_en}, {31'b0, erd != 5'd0});
        if (erd != 5'd0) begin
          chk(sz == 3 ? "R6" : "R2", "wb_idx", {27'b0, wb_idx}, {27'b0, erd});
          chk(sz >= 2 ? "R3" : "R2", "wb_data", wb_data, v);
        end
      end
    end else begin
      chk(sz < 0 ? "R8" : "R7", "wb_en idle", {31'b0, wb_en}, 32'd0);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R6", "busy", {31'b0, busy}, {31'b0, en && sz == 3});
    if (en && sz == 3) begin
      chk("R10", "req_ready", {31'b0, req_ready}, 32'd0);
      chk("R6", "beat2 addr", mem_addr, a + 32'd4);
      chk("R6", "beat2 be", {28'b0, mem_be}, 32'hF);
      if (st) chk("R6", "beat2 wdata", mem_wdata, sd[63:32]);
      else begin
        chk("R6", "beat2 wb_idx", {27'b0, wb_idx}, {27'b0, rd[4:1], 1'b1});
        chk("R6", "beat2 wb_en", {31'b0, wb_en}, 32'd1);
        chk("R6", "beat2 wb_data", wb_data, mem[a[5:2] + 4'd1]);
      end
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R6", "busy end", {31'b0, busy}, 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h80F1_7E02 ^ (i * 32'h1357_9BDF);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R9", "busy", {31'b0, busy}, 32'd0);
    chk("R9", "req_ready", {31'b0, req_ready}, 32'd1);
    chk("R9", "mem_en", {31'b0, mem_en}, 32'd0);
    chk("R9", "wb_en", {31'b0, wb_en}, 32'd0);
    chk("R9", "misalign", {31'b0, misalign}, 32'd0);
    rst_n = 1'b1;

    // Sweep: every code, eight offsets straddling a word boundary, two bases.
    for (int b = 0; b < 2; b++)
      for (int op = 0; op < 16; op++)
        for (int off = 0; off < 8; off++)
          do_op(4'(op), (off == 3) ? 5'd0 : 5'((op * 7 + off) % 32),
                b == 0 ? 32'h0000_0040 : 32'h0001_0020, 16'(off - 4),
                {32'hA5C3_1E97 ^ (op * 32'h0101_0101), 32'h6B8D_F20C + 32'(off * 9)});

    // R1: large negative immediate wraps the address
    do_op(4'd4, 5'd9, 32'h0000_1008, 16'hF000, 64'd0);
    // R5 with R6: pair 0/1 drops only the even writeback
    do_op(4'd6, 5'd1, 32'h0000_0020, 16'h0000, 64'd0);

    // R10: request held during the second beat of a double store
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'd12; req_rd = 5'd4; req_base = 32'h30; req_imm = 16'h0;
    req_sdata = 64'h1122_3344_5566_7788;
    @(posedge clk);
    @(negedge clk);
    req_op = 4'd4; req_rd = 5'd7; req_base = 32'h08; req_sdata = 64'd0;
    #1;
    chk("R10", "ready low", {31'b0, req_ready}, 32'd0);
    chk("R10", "beat2 addr", mem_addr, 32'h34);
    chk("R10", "beat2 we", {31'b0, mem_we}, 32'd1);
    chk("R10", "beat2 wdata", mem_wdata, 32'h1122_3344);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R10", "ready back", {31'b0, req_ready}, 32'd1);
    chk("R10", "held addr", mem_addr, 32'h08);
    chk("R10", "held we", {31'b0, mem_we}, 32'd0);
    chk("R10", "held wb_idx", {27'b0, wb_idx}, 32'd7);
    chk("R10", "held wb_data", wb_data, mem[2]);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R10", "stored lo", mem[12], 32'h5566_7788);
    chk("R10", "stored hi", mem[13], 32'h1122_3344);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule